// File: doc/BRIEF.md
# Display Format Decoder and Latch

This block turns the raw display set-up fields into a frame descriptor once per frame. When a frame-present strobe arrives, it samples the packed size word, the mode fields (display enable and pixel-format select), the configuration flags (video out, interlace, blank) and the border colour. From these it works out the horizontal and vertical resolution in pixels, the pixel format, the row stride in bytes and whether output is enabled. The results are held in output registers until the next accepted strobe.

The size word holds three packed fields. Words per line minus one sits in the lowest field. Lines per field minus one sits in the middle field. Modulo plus one sits in the top field. Horizontal resolution depends on how pixels pack into 32-bit words. The 24-bit packing needs a division by three, which a bit-serial divider performs. Each descriptor also carries a format-changed flag, set when the new resolution or pixel format differs from the one held before. A frame with output disabled clears the held resolution, so the next enabled frame always reports a change. A single-cycle done pulse marks each new descriptor. Strobes that arrive while a frame is being decoded are ignored.

Top module: `frame_desc_latch`

## Requirements
- R1: After reset, all descriptor outputs are zero, and frameDone, fmtChanged and busy are low.
- R2: The size word carries words-per-line minus one in bits F-1:0, lines-per-field minus one in bits 2F-1:F, and modulo plus one in bits 3F-1:2F (F = FIELD_W). The row stride output is (words field + modulo field) × 4 bytes, which equals (words + modulo) × 4.
- R3: The pixelFmt output latches the 2-bit format select: 0 = 16-bit with 1-bit alpha, 1 = 16-bit 5-6-5, 2 = 24-bit packed, 3 = 32-bit.
- R4: hRes is twice the words per line for codes 0 and 1, floor(words × 4 / 3) for code 2, and equal to the words per line for code 3.
- R5: vRes equals the lines per field, or twice that value when the interlace flag is set.
- R6: Output is enabled only when both the display-enable and video-out inputs are high. A disabled frame sets hRes, vRes, outEnable, blanked and fmtChanged to zero.
- R7: fmtChanged is high for an enabled frame whose hRes, vRes or pixel format differs from the values held before it. After a disabled frame, the next enabled frame always reports a change.
- R8: An enabled frame with the blank flag set reports blanked high, and borderOut takes the sampled border colour.
- R9: Each accepted strobe gives exactly one single-cycle frameDone pulse. busy is high from the cycle after the strobe until frameDone. The outputs change only together with frameDone. A strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presentStrobe | input | 1 | Frame-present request; sampled when idle |
| sizeWord | input | 3*FIELD_W | Packed modulo, lines and words fields |
| modeEnable | input | 1 | Display-enable field of the mode register |
| modeFmt | input | 2 | Pixel-format select of the mode register |
| cfgVideoOut | input | 1 | Video-out flag of the configuration register |
| cfgInterlace | input | 1 | Interlace flag of the configuration register |
| cfgBlank | input | 1 | Blank flag (bit 3 of the second configuration register) |
| borderColour | input | COLOUR_W | Border colour to show when blanked |
| hRes | output | FIELD_W+2 | Horizontal resolution in pixels |
| vRes | output | FIELD_W+2 | Vertical resolution in lines |
| pixelFmt | output | 2 | Latched pixel format code |
| rowStride | output | FIELD_W+3 | Row stride in bytes |
| outEnable | output | 1 | Output enabled for the latched frame |
| blanked | output | 1 | Frame shows the border colour instead of memory |
| borderOut | output | COLOUR_W | Latched border colour |
| fmtChanged | output | 1 | Format differs from the previous descriptor |
| frameDone | output | 1 | Single-cycle pulse when a descriptor is written |
| busy | output | 1 | A frame decode is in progress |

## Verification
The bench builds the block with its default field width of ten bits and a 32-bit border colour. This lets it reach the smallest and largest word counts (1 and 1024) through the divide-by-three path. It also reaches the largest interlaced height (2048 lines) and strides that use the full modulo field. Because the field width sets both the divider length and the output widths, these defaults cover the widest quotient and the carry into the top stride bit. The scoreboard keeps its own record of the previous descriptor, so change detection is checked across format-only switches, repeated frames and recovery from disabled frames.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

  typedef enum logic [1:0] {
    PF_A1RGB15 = 2'd0,
    PF_RGB16   = 2'd1,
    PF_RGB24   = 2'd2,
    PF_ARGB32  = 2'd3
  } pixFmt_e;

  // strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic divLoad;
    logic divStep;
    logic commit;
  } dpCtl_t;

endpackage

// File: rtl/dfl_ctrl.sv
module dfl_ctrl
  import dfl_pkg::*;
#(
  parameter int DIV_STEPS = 13
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   presentStrobe,
  input  logic   needDiv,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   frameDone
);

  localparam int CNT_W = (DIV_STEPS > 1) ? $clog2(DIV_STEPS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_DIV, S_COMMIT} state_e;

  state_e stateQ, stateD;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (presentStrobe) begin
          ctl.capture = 1'b1;
          stateD      = S_EVAL;
        end
      end
      S_EVAL: begin
        if (needDiv) begin
          ctl.divLoad = 1'b1;
          stateD      = S_DIV;
        end else begin
          stateD = S_COMMIT;
        end
      end
      S_DIV: begin
        ctl.divStep = 1'b1;
        if (stepCnt == CNT_W'(DIV_STEPS - 1)) stateD = S_COMMIT;
      end
      S_COMMIT: begin
        ctl.commit = 1'b1;
        stateD     = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ    <= S_IDLE;
      stepCnt   <= '0;
      frameDone <= 1'b0;
    end else begin
      stateQ    <= stateD;
      frameDone <= ctl.commit;
      if (ctl.divLoad)      stepCnt <= '0;
      else if (ctl.divStep) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (stateQ != S_IDLE);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);

  // R9
  strobe_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctl.commit) |=> busy);

endmodule

// File: rtl/dfl_datapath.sv
module dfl_datapath
  import dfl_pkg::*;
#(
  parameter int FIELD_W  = 10,
  parameter int COLOUR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dpCtl_t                ctl,
  input  logic [3*FIELD_W-1:0]  sizeWord,
  input  logic                  modeEnable,
  input  logic [1:0]            modeFmt,
  input  logic                  cfgVideoOut,
  input  logic                  cfgInterlace,
  input  logic                  cfgBlank,
  input  logic [COLOUR_W-1:0]   borderColour,
  output logic                  needDiv,
  output logic [FIELD_W+1:0]    hRes,
  output logic [FIELD_W+1:0]    vRes,
  output pixFmt_e               pixelFmt,
  output logic [FIELD_W+2:0]    rowStride,
  output logic                  outEnable,
  output logic                  blanked,
  output logic [COLOUR_W-1:0]   borderOut,
  output logic                  fmtChanged
);

  localparam int WORDS_W  = FIELD_W + 1;
  localparam int RES_W    = FIELD_W + 2;
  localparam int STRIDE_W = FIELD_W + 3;
  localparam int DIV_W    = FIELD_W + 3;

  // sampled frame set-up
  logic [FIELD_W-1:0]  wordFld, lineFld, modFld;
  pixFmt_e             fmtQ;
  logic                enQ, laceQ, blankQ;
  logic [COLOUR_W-1:0] borderQ;

  // serial divide-by-three state
  logic [DIV_W-1:0] divNum;
  logic [1:0]       divRem;
  logic [RES_W-1:0] divQuot;
  logic [2:0]       trial;
  logic             trialGe;

  logic [WORDS_W-1:0]  wordsCnt;
  logic [WORDS_W-1:0]  linesCnt;
  logic [RES_W-1:0]    hResNext, vResNext;
  logic [STRIDE_W-1:0] strideNext;
  logic                diffNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordFld <= '0;
      lineFld <= '0;
      modFld  <= '0;
      fmtQ    <= PF_A1RGB15;
      enQ     <= 1'b0;
      laceQ   <= 1'b0;
      blankQ  <= 1'b0;
      borderQ <= '0;
    end else if (ctl.capture) begin
      wordFld <= sizeWord[FIELD_W-1:0];
      lineFld <= sizeWord[2*FIELD_W-1:FIELD_W];
      modFld  <= sizeWord[3*FIELD_W-1:2*FIELD_W];
      fmtQ    <= pixFmt_e'(modeFmt);
      enQ     <= modeEnable & cfgVideoOut;
      laceQ   <= cfgInterlace;
      blankQ  <= cfgBlank;
      borderQ <= borderColour;
    end
  end

  assign wordsCnt = WORDS_W'(wordFld) + 1'b1;
  assign linesCnt = WORDS_W'(lineFld) + 1'b1;
  assign needDiv  = enQ && (fmtQ == PF_RGB24);

  // restoring division of (words * 4) by three, one quotient bit per step
  assign trial   = {divRem, divNum[DIV_W-1]};
  assign trialGe = (trial >= 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divNum  <= '0;
      divRem  <= '0;
      divQuot <= '0;
    end else if (ctl.divLoad) begin
      divNum  <= {wordsCnt, 2'b00};
      divRem  <= '0;
      divQuot <= '0;
    end else if (ctl.divStep) begin
      divNum  <= {divNum[DIV_W-2:0], 1'b0};
      divRem  <= trialGe ? 2'(trial - 3'd3) : trial[1:0];
      divQuot <= {divQuot[RES_W-2:0], trialGe};
    end
  end

  always_comb begin
    unique case (fmtQ)
      PF_A1RGB15, PF_RGB16: hResNext = {wordsCnt, 1'b0};
      PF_RGB24:             hResNext = divQuot;
      default:              hResNext = RES_W'(wordsCnt);
    endcase
  end

  assign vResNext   = laceQ ? {linesCnt, 1'b0} : RES_W'(linesCnt);
  assign strideNext = {(WORDS_W'(wordFld) + WORDS_W'(modFld)), 2'b00};
  // the held outputs double as the previous-frame record
  assign diffNext   = (hResNext != hRes) || (vResNext != vRes) || (fmtQ != pixelFmt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hRes       <= '0;
      vRes       <= '0;
      pixelFmt   <= PF_A1RGB15;
      rowStride  <= '0;
      outEnable  <= 1'b0;
      blanked    <= 1'b0;
      borderOut  <= '0;
      fmtChanged <= 1'b0;
    end else if (ctl.commit) begin
      if (enQ) begin
        hRes       <= hResNext;
        vRes       <= vResNext;
        pixelFmt   <= fmtQ;
        rowStride  <= strideNext;
        outEnable  <= 1'b1;
        blanked    <= blankQ;
        borderOut  <= borderQ;
        fmtChanged <= diffNext;
      end else begin
        hRes       <= '0;
        vRes       <= '0;
        outEnable  <= 1'b0;
        blanked    <= 1'b0;
        fmtChanged <= 1'b0;
      end
    end
  end

  // R4
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.commit && needDiv) |->
      ((32'(divQuot) * 3 <= 32'(wordsCnt) * 4) && (32'(wordsCnt) * 4 < 32'(divQuot) * 3 + 3)));

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.commit |=> ($stable(hRes) && $stable(vRes) && $stable(rowStride) && $stable(outEnable)));

endmodule

// File: rtl/frame_desc_latch.sv
module frame_desc_latch
  import dfl_pkg::*;
#(
  parameter int FIELD_W  = 10,
  parameter int COLOUR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 presentStrobe,
  input  logic [3*FIELD_W-1:0] sizeWord,
  input  logic                 modeEnable,
  input  logic [1:0]           modeFmt,
  input  logic                 cfgVideoOut,
  input  logic                 cfgInterlace,
  input  logic                 cfgBlank,
  input  logic [COLOUR_W-1:0]  borderColour,
  output logic [FIELD_W+1:0]   hRes,
  output logic [FIELD_W+1:0]   vRes,
  output logic [1:0]           pixelFmt,
  output logic [FIELD_W+2:0]   rowStride,
  output logic                 outEnable,
  output logic                 blanked,
  output logic [COLOUR_W-1:0]  borderOut,
  output logic                 fmtChanged,
  output logic                 frameDone,
  output logic                 busy
);

  localparam int DIV_STEPS = FIELD_W + 3;

  dpCtl_t  ctl;
  logic    needDiv;
  pixFmt_e fmtOut;

  dfl_ctrl #(.DIV_STEPS(DIV_STEPS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .presentStrobe(presentStrobe),
    .needDiv      (needDiv),
    .ctl          (ctl),
    .busy         (busy),
    .frameDone    (frameDone)
  );

  dfl_datapath #(.FIELD_W(FIELD_W), .COLOUR_W(COLOUR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .sizeWord    (sizeWord),
    .modeEnable  (modeEnable),
    .modeFmt     (modeFmt),
    .cfgVideoOut (cfgVideoOut),
    .cfgInterlace(cfgInterlace),
    .cfgBlank    (cfgBlank),
    .borderColour(borderColour),
    .needDiv     (needDiv),
    .hRes        (hRes),
    .vRes        (vRes),
    .pixelFmt    (fmtOut),
    .rowStride   (rowStride),
    .outEnable   (outEnable),
    .blanked     (blanked),
    .borderOut   (borderOut),
    .fmtChanged  (fmtChanged)
  );

  assign pixelFmt = fmtOut;

  // R6
  zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameDone && !outEnable) |-> (hRes == '0 && vRes == '0 && !fmtChanged && !blanked));

  // R5
  vres_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameDone && outEnable) |-> (vRes != '0 && hRes != '0));

  // R8
  blank_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blanked |-> outEnable);

  // R9
  busy_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> !busy);

endmodule

// File: tb/frame_desc_latch_test.sv
module frame_desc_latch_test;

  localparam int FW = 10;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic presentStrobe = 1'b0;
  logic [3*FW-1:0] sizeWord = '0;
  logic modeEnable = 1'b0;
  logic [1:0] modeFmt = '0;
  logic cfgVideoOut = 1'b0, cfgInterlace = 1'b0, cfgBlank = 1'b0;
  logic [CW-1:0] borderColour = '0;
  logic [FW+1:0] hRes, vRes;
  logic [1:0] pixelFmt;
  logic [FW+2:0] rowStride;
  logic outEnable, blanked, fmtChanged, frameDone, busy;
  logic [CW-1:0] borderOut;

  always #5 clk = ~clk;

  frame_desc_latch #(.FIELD_W(FW), .COLOUR_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .presentStrobe(presentStrobe), .sizeWord(sizeWord),
    .modeEnable(modeEnable), .modeFmt(modeFmt), .cfgVideoOut(cfgVideoOut),
    .cfgInterlace(cfgInterlace), .cfgBlank(cfgBlank), .borderColour(borderColour),
    .hRes(hRes), .vRes(vRes), .pixelFmt(pixelFmt), .rowStride(rowStride),
    .outEnable(outEnable), .blanked(blanked), .borderOut(borderOut),
    .fmtChanged(fmtChanged), .frameDone(frameDone), .busy(busy)
  );

  typedef struct {
    int en; int h; int v; int fmt; int stride; int blank; int border; int chg;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  int prevH = 0, prevV = 0, prevF = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop and compare on every descriptor
  always @(negedge clk) begin
    if (rst_n && frameDone) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected frameDone", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(outEnable) == e.en, "R6 outEnable", int'(outEnable), e.en);
        check(int'(hRes) == e.h, "R4 hRes", int'(hRes), e.h);
        check(int'(vRes) == e.v, "R5 vRes", int'(vRes), e.v);
        check(int'(fmtChanged) == e.chg, "R7 fmtChanged", int'(fmtChanged), e.chg);
        check(int'(blanked) == e.blank, "R8 blanked", int'(blanked), e.blank);
        if (e.en != 0) begin
          check(int'(pixelFmt) == e.fmt, "R3 pixelFmt", int'(pixelFmt), e.fmt);
          check(int'(rowStride) == e.stride, "R2 rowStride", int'(rowStride), e.stride);
          check(int'(borderOut) == e.border, "R8 borderOut", int'(borderOut), e.border);
        end
        @(negedge clk);
        check(!frameDone, "R9 single pulse", int'(frameDone), 0);
      end
    end
  end

  function automatic exp_t model(input int wf, input int lf, input int mf, input int fmt,
                                 input bit en, input bit lace, input bit blank, input int border);
    exp_t e;
    int words;
    words = wf + 1;
    e.en = en; e.fmt = fmt; e.border = border;
    e.stride = (wf + mf) * 4;
    case (fmt)
      0, 1:    e.h = words * 2;
      2:       e.h = (words * 4) / 3;
      default: e.h = words;
    endcase
    e.v = lace ? (lf + 1) * 2 : lf + 1;
    if (en) begin
      e.blank = blank;
      e.chg = (e.h != prevH || e.v != prevV || fmt != prevF) ? 1 : 0;
      prevH = e.h; prevV = e.v; prevF = fmt;
    end else begin
      e.h = 0; e.v = 0; e.blank = 0; e.chg = 0;
      prevH = 0; prevV = 0;
    end
    return e;
  endfunction

  task automatic setRegs(input int wf, input int lf, input int mf, input int fmt,
                         input bit de, input bit vo, input bit lace, input bit blank, input int border);
    sizeWord     = {FW'(mf), FW'(lf), FW'(wf)};
    modeEnable   = de;
    modeFmt      = 2'(fmt);
    cfgVideoOut  = vo;
    cfgInterlace = lace;
    cfgBlank     = blank;
    borderColour = CW'(border);
  endtask

  task automatic waitDone(input string req);
    bit seen = 0;
    for (int k = 0; k < 64 && !seen; k++) begin
      @(negedge clk);
      if (frameDone) seen = 1;
    end
    if (!seen) check(1'b0, req, 0, 1);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic present(input int wf, input int lf, input int mf, input int fmt,
                         input bit de, input bit vo, input bit lace, input bit blank, input int border);
    sb.push_back(model(wf, lf, mf, fmt, de & vo, lace, blank, border));
    setRegs(wf, lf, mf, fmt, de, vo, lace, blank, border);
    @(negedge clk);
    presentStrobe = 1'b1;
    @(negedge clk);
    presentStrobe = 1'b0;
    check(busy, "R9 busy after strobe", int'(busy), 1);
    waitDone("R9 frameDone timeout");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hRes == 0 && vRes == 0 && rowStride == 0, "R1 reset resolution", int'(hRes), 0);
    check(!outEnable && !blanked && !fmtChanged && borderOut == 0, "R1 reset flags", int'(outEnable), 0);
    check(!frameDone && !busy && pixelFmt == 0, "R1 reset control", int'(busy), 0);

    // 16-bit 5-6-5, then a repeat of the same frame (R7 no change)
    present(319, 239, 1, 1, 1, 1, 0, 0, 0);
    present(319, 239, 1, 1, 1, 1, 0, 0, 0);
    // only the format code changes (R3, R7)
    present(319, 239, 1, 0, 1, 1, 0, 0, 0);
    // 32-bit with the same width in pixels (R4)
    present(639, 239, 5, 3, 1, 1, 0, 0, 0);
    // 24-bit packing through the divider (R4)
    present(479, 239, 0, 2, 1, 1, 0, 0, 0);
    present(0, 0, 0, 2, 1, 1, 0, 0, 0);
    present(1023, 1023, 1023, 2, 1, 1, 1, 0, 0);
    present(2, 10, 3, 2, 1, 1, 0, 0, 0);
    present(3, 10, 3, 2, 1, 1, 0, 0, 0);
    // interlace doubling (R5)
    present(639, 239, 1, 3, 1, 1, 1, 0, 0);
    // disabled by mode, then the same frame re-enabled must report a change (R6, R7)
    present(639, 239, 1, 3, 0, 1, 1, 0, 0);
    present(639, 239, 1, 3, 1, 1, 1, 0, 0);
    // disabled by video-out flag (R6)
    present(100, 50, 7, 1, 1, 0, 0, 1, 32'h1234);
    // blanked frame with border colour (R8)
    present(100, 50, 7, 1, 1, 1, 0, 1, 32'h00AB_CDEF);
    present(100, 50, 7, 1, 1, 1, 0, 0, 32'h0055_5555);

    // R9: a second strobe while busy is ignored
    sb.push_back(model(599, 199, 2, 2, 1, 0, 0, 0));
    setRegs(599, 199, 2, 2, 1, 1, 0, 0, 0);
    @(negedge clk);
    presentStrobe = 1'b1;
    @(negedge clk);
    presentStrobe = 1'b0;
    setRegs(5, 5, 5, 3, 1, 1, 1, 1, 77);
    @(negedge clk);
    presentStrobe = 1'b1;
    check(busy, "R9 busy during divide", int'(busy), 1);
    @(negedge clk);
    presentStrobe = 1'b0;
    waitDone("R9 frameDone timeout");
    repeat (20) @(negedge clk);
    check(int'(hRes) == 800, "R9 outputs held after ignored strobe", int'(hRes), 800);
    check(!busy && sb.size() == 0, "R9 no extra frame", sb.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule